// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block lets software program and inspect a one-time-programmable fuse array of 8 banks of 256 bytes through a 32-bit register bus. A bus address with bit 11 clear selects a control register. A bus address with bit 11 set selects a fuse window. Software places a bank, a row and a bit index in two byte-wide address registers. It then starts either a program cycle, which blows that single bit, or an explicit sense cycle, which fetches the addressed fuse byte into a sense data register. Each cycle keeps a busy flag high for a fixed number of clocks. It sets a completion flag or an error flag when it ends.

Each fuse byte also has a shadow copy. Software reads the shadow copy, and may overwrite it, through a per-bank window. Programming a bit sets the same bit in both the fuse and its shadow copy. Three per-bank protection inputs block window reads and sensing, programming, and shadow overrides. A blocked access only raises its own error flag. The physical fuse macro is modelled by storage inside the block that resets to all zero. An interrupt output combines the status and error flags with their mask registers.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Register word offsets are: 0 function control, 1 upper address, 2 lower address, 3 program key, 4 sense data, 5 status, 6 status mask, 7 error, 8 error mask, 9 product revision, 10 silicon revision. All registers reset to zero except the two revision registers, which read their parameter values. Control registers occupy the low byte of the bus word.
- R2: Bus address 0x800 + bank*256 + row reads and writes the shadow byte of that fuse location in bits 7:0. The shadow copy resets to 0.
- R3: A window write to a bank whose override-protect input is high leaves the shadow byte unchanged and sets error bit 5.
- R4: A window read of a bank whose read-protect input is high returns 0 and sets error bit 4.
- R5: Writing 1 to function control bit 0 while the key register does not hold 0xAA starts no cycle, changes no fuse, leaves status bit 1 clear and sets error bit 7.
- R6: With key 0xAA, writing 1 to function control bit 0 programs a single fuse bit. The bank is upper address bits 5:3. The row is {upper address bits 2:0, lower address bits 7:3}. The bit index is lower address bits 2:0. At the end of the cycle that bit is set in both the fuse and its shadow copy, and status bit 1 is set. Programming a byte needs one cycle for each set bit.
- R7: A program request with the correct key to a bank whose write-protect input is high starts no cycle, changes no fuse, leaves status bit 1 clear and sets error bit 6.
- R8: Writing 1 to function control bit 3 starts a sense cycle. If the addressed bank is not read-protected when the cycle ends, the fuse byte is loaded into the sense data register and status bit 0 is set. If the bank is read-protected, error bit 2 is set, status bit 0 stays clear and the sense data register keeps its value.
- R9: After an accepted start, status bit 7 (busy) reads 1 for exactly BUSY_CYCLES clock cycles. Any function control write made while busy is high is ignored.
- R10: Status bits 1:0 and error bits 7:1 are write-1-to-clear, so writing back a value just read clears every flag it showed. Status bit 7 is read-only.
- R11: irq is high exactly when a set status bit has its status-mask bit set (mask bits 1:0) or a set error bit has its error-mask bit set (mask bits 7:1).
- R12: If bits 0 and 3 are written together, only the program cycle runs. Function control bits 6:4 hold a pulse-length field that reads back as written. The start bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; only used for window read protection |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data; bits 7:0 used |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rd_prot | input | NUM_BANKS | Per-bank read protection (window read and sense) |
| wr_prot | input | NUM_BANKS | Per-bank program protection |
| ovr_prot | input | NUM_BANKS | Per-bank shadow override protection |
| irq | output | 1 | Masked status or error pending |

## Verification
A wrong busy counter is visible on the status register. Busy stays high for the wrong number of cycles, or a second start is taken while a cycle is running, and this shows on the first poll. A wrong address split, or a program cycle that blows more than one bit, appears as a wrong sense byte right after that cycle. It also appears as a mismatch in the final window sweep, which compares all 2048 shadow bytes with a model. Protection faults appear on the error register in the cycle after the blocked access. The fuse or shadow byte that the access could have changed is then read back.

// File: rtl/otp_fuse_pkg.sv
`timescale 1ns/1ps
package otp_fuse_pkg;
  // bus and field geometry (fixed by the register layout)
  localparam int BUS_AW = 12;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 8;
  localparam int IDX_W  = BANK_W + ROW_W;

  // register word offsets
  localparam logic [3:0] OFS_FCTL  = 4'd0;
  localparam logic [3:0] OFS_UADDR = 4'd1;
  localparam logic [3:0] OFS_LADDR = 4'd2;
  localparam logic [3:0] OFS_KEY   = 4'd3;
  localparam logic [3:0] OFS_SDATA = 4'd4;
  localparam logic [3:0] OFS_STAT  = 4'd5;
  localparam logic [3:0] OFS_STATM = 4'd6;
  localparam logic [3:0] OFS_ERR   = 4'd7;
  localparam logic [3:0] OFS_ERRM  = 4'd8;
  localparam logic [3:0] OFS_PREV  = 4'd9;
  localparam logic [3:0] OFS_SREV  = 4'd10;

  localparam logic [7:0] PROG_KEY = 8'hAA;

  // error bit positions
  localparam int EB_PROG = 7;
  localparam int EB_WP   = 6;
  localparam int EB_OVR  = 5;
  localparam int EB_RD   = 4;
  localparam int EB_SNS  = 2;
  localparam logic [7:0] ERR_IMPL = 8'hFE;

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_SENSE} fuse_op_e;

  function automatic logic [BANK_W-1:0] bank_of(input logic [5:0] ua);
    return ua[5:3];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [5:0] ua, input logic [7:0] la);
    return {ua[2:0], la[7:3]};
  endfunction

  function automatic logic [2:0] bit_of(input logic [7:0] la);
    return la[2:0];
  endfunction

  function automatic logic [IDX_W-1:0] flat_idx(input logic [BANK_W-1:0] b,
                                                input logic [ROW_W-1:0] r);
    return {b, r};
  endfunction
endpackage

// File: rtl/otp_fuse_array.sv
`timescale 1ns/1ps
module otp_fuse_array import otp_fuse_pkg::*; #(
  parameter int NUM_BANKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [BANK_W-1:0] prog_bank,
  input  logic [ROW_W-1:0]  prog_row,
  input  logic [2:0]        prog_bit,
  input  logic              ovr_en,
  input  logic [BANK_W-1:0] ovr_bank,
  input  logic [ROW_W-1:0]  ovr_row,
  input  logic [7:0]        ovr_data,
  input  logic [BANK_W-1:0] win_bank,
  input  logic [ROW_W-1:0]  win_row,
  output logic [7:0]        win_byte,
  input  logic [BANK_W-1:0] sns_bank,
  input  logic [ROW_W-1:0]  sns_row,
  output logic [7:0]        sns_byte
);
  localparam int DEPTH = NUM_BANKS * (1 << ROW_W);

  logic [7:0] fuse_mem   [DEPTH];
  logic [7:0] shadow_mem [DEPTH];

  function automatic logic in_range(input logic [BANK_W-1:0] b);
    return int'(b) < NUM_BANKS;
  endfunction

  logic              prog_ok, ovr_ok, same_byte;
  logic [IDX_W-1:0]  prog_i, ovr_i, win_i, sns_i;
  logic [7:0]        prog_mask;

  assign prog_i    = flat_idx(prog_bank, prog_row);
  assign ovr_i     = flat_idx(ovr_bank, ovr_row);
  assign win_i     = flat_idx(win_bank, win_row);
  assign sns_i     = flat_idx(sns_bank, sns_row);
  assign prog_ok   = prog_en && in_range(prog_bank);
  assign ovr_ok    = ovr_en && in_range(ovr_bank);
  assign same_byte = ovr_ok && (ovr_i == prog_i);
  assign prog_mask = 8'(1) << prog_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        fuse_mem[i]   <= '0;
        shadow_mem[i] <= '0;
      end
    end else begin
      if (ovr_ok) shadow_mem[ovr_i] <= ovr_data;
      if (prog_ok) begin
        fuse_mem[prog_i]   <= fuse_mem[prog_i] | prog_mask;
        shadow_mem[prog_i] <= (same_byte ? ovr_data : shadow_mem[prog_i]) | prog_mask;
      end
    end
  end

  assign win_byte = in_range(win_bank) ? shadow_mem[win_i] : 8'h00;
  assign sns_byte = in_range(sns_bank) ? fuse_mem[sns_i]   : 8'h00;
endmodule

// File: rtl/otp_fuse_seq.sv
`timescale 1ns/1ps
module otp_fuse_seq import otp_fuse_pkg::*; #(
  parameter int BUSY_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_prog,
  input  logic              go_sense,
  input  logic [BANK_W-1:0] tgt_bank,
  input  logic [ROW_W-1:0]  tgt_row,
  input  logic [2:0]        tgt_bit,
  output logic              busy,
  output logic              end_prog,
  output logic              end_sense,
  output logic [BANK_W-1:0] lat_bank,
  output logic [ROW_W-1:0]  lat_row,
  output logic [2:0]        lat_bit
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  fuse_op_e         op_q;
  logic             last_cycle;

  assign last_cycle = busy && (cnt_q == CNT_W'(1));
  assign end_prog   = last_cycle && (op_q == OP_PROG);
  assign end_sense  = last_cycle && (op_q == OP_SENSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      op_q     <= OP_IDLE;
      lat_bank <= '0;
      lat_row  <= '0;
      lat_bit  <= '0;
    end else if (!busy && (go_prog || go_sense)) begin
      busy     <= 1'b1;
      cnt_q    <= CNT_LOAD;
      op_q     <= go_prog ? OP_PROG : OP_SENSE;
      lat_bank <= tgt_bank;
      lat_row  <= tgt_row;
      lat_bit  <= tgt_bit;
    end else if (last_cycle) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      op_q  <= OP_IDLE;
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_fuse_ctrl import otp_fuse_pkg::*; #(
  parameter int         NUM_BANKS   = 8,
  parameter int         BUSY_CYCLES = 6,
  parameter logic [7:0] PROD_REV    = 8'h31,
  parameter logic [7:0] SIL_REV     = 8'h02
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_BANKS-1:0] rd_prot,
  input  logic [NUM_BANKS-1:0] wr_prot,
  input  logic [NUM_BANKS-1:0] ovr_prot,
  output logic                 irq
);
  function automatic logic prot_at(input logic [NUM_BANKS-1:0] v, input logic [BANK_W-1:0] b);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (int'(b) == i) hit = v[i];
    return hit;
  endfunction

  // registers
  logic [2:0] fctl_len_q;
  logic [5:0] ua_q;
  logic [7:0] la_q, key_q, sdat_q, err_q, errm_q;
  logic       prgd_q, snsd_q;
  logic [1:0] statm_q;

  // bus decode
  logic             win_hit, reg_sel, reg_wr;
  logic [3:0]       ofs;
  logic [BANK_W-1:0] win_bank;
  logic [ROW_W-1:0]  win_row;
  logic [7:0]       wbyte;
  logic             unused_wdata;

  assign win_hit  = bus_addr[BUS_AW-1];
  assign reg_sel  = !bus_addr[BUS_AW-1] && (bus_addr[BUS_AW-2:4] == '0);
  assign ofs      = bus_addr[3:0];
  assign reg_wr   = bus_wr && reg_sel;
  assign win_bank = bus_addr[10:8];
  assign win_row  = bus_addr[7:0];
  assign wbyte    = bus_wdata[7:0];
  assign unused_wdata = ^bus_wdata[31:8];

  // operation requests
  logic seq_busy, end_prog, end_sense;
  logic [BANK_W-1:0] lat_bank;
  logic [ROW_W-1:0]  lat_row;
  logic [2:0]        lat_bit;
  logic [BANK_W-1:0] tgt_bank;
  logic [ROW_W-1:0]  tgt_row;
  logic [2:0]        tgt_bit;
  logic wr_fctl, req_prog, req_sense, key_ok, tgt_wp;
  logic acc_prog, acc_sense, rej_key, rej_wp;
  logic sns_fail, sns_ok;

  assign tgt_bank  = bank_of(ua_q);
  assign tgt_row   = row_of(ua_q, la_q);
  assign tgt_bit   = bit_of(la_q);
  assign wr_fctl   = reg_wr && (ofs == OFS_FCTL) && !seq_busy;
  assign req_prog  = wr_fctl && wbyte[0];
  assign req_sense = wr_fctl && wbyte[3] && !wbyte[0];
  assign key_ok    = (key_q == PROG_KEY);
  assign tgt_wp    = prot_at(wr_prot, tgt_bank);
  assign rej_key   = req_prog && !key_ok;
  assign rej_wp    = req_prog && key_ok && tgt_wp;
  assign acc_prog  = req_prog && key_ok && !tgt_wp;
  assign acc_sense = req_sense;
  assign sns_fail  = end_sense && prot_at(rd_prot, lat_bank);
  assign sns_ok    = end_sense && !sns_fail;

  // window accesses
  logic win_wr, win_rd, ovr_blocked, ovr_do, rd_blocked, win_rd_prot;
  logic [7:0] win_byte, sns_byte;

  assign win_wr      = bus_wr && win_hit;
  assign win_rd      = bus_rd && win_hit;
  assign win_rd_prot = prot_at(rd_prot, win_bank);
  assign ovr_blocked = win_wr && prot_at(ovr_prot, win_bank);
  assign ovr_do      = win_wr && !ovr_blocked;
  assign rd_blocked  = win_rd && win_rd_prot;

  // flag updates
  logic [7:0] err_set, err_clr;
  logic [1:0] stat_clr;
  logic       err_wipe;

  always_comb begin
    err_set          = '0;
    err_set[EB_PROG] = rej_key;
    err_set[EB_WP]   = rej_wp;
    err_set[EB_OVR]  = ovr_blocked;
    err_set[EB_RD]   = rd_blocked;
    err_set[EB_SNS]  = sns_fail;
  end

  assign err_clr  = (reg_wr && ofs == OFS_ERR)  ? wbyte : 8'h00;
  assign stat_clr = (reg_wr && ofs == OFS_STAT) ? wbyte[1:0] : 2'b00;
  assign err_wipe = reg_wr && (ofs == OFS_ERR) && ((wbyte & ERR_IMPL) == ERR_IMPL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fctl_len_q <= '0;
      ua_q       <= '0;
      la_q       <= '0;
      key_q      <= '0;
      sdat_q     <= '0;
      prgd_q     <= 1'b0;
      snsd_q     <= 1'b0;
      statm_q    <= '0;
      err_q      <= '0;
      errm_q     <= '0;
    end else begin
      if (reg_wr) begin
        unique case (ofs)
          OFS_FCTL:  if (!seq_busy) fctl_len_q <= wbyte[6:4];
          OFS_UADDR: ua_q    <= wbyte[5:0];
          OFS_LADDR: la_q    <= wbyte;
          OFS_KEY:   key_q   <= wbyte;
          OFS_STATM: statm_q <= wbyte[1:0];
          OFS_ERRM:  errm_q  <= wbyte & ERR_IMPL;
          default: ;
        endcase
      end
      prgd_q <= (prgd_q && !stat_clr[1]) || end_prog;
      snsd_q <= (snsd_q && !stat_clr[0]) || sns_ok;
      err_q  <= ((err_q & ~err_clr) | err_set) & ERR_IMPL;
      if (sns_ok) sdat_q <= sns_byte;
    end
  end

  assign irq = |({prgd_q, snsd_q} & statm_q) | |(err_q & errm_q);

  otp_fuse_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_prog   (acc_prog),
    .go_sense  (acc_sense),
    .tgt_bank  (tgt_bank),
    .tgt_row   (tgt_row),
    .tgt_bit   (tgt_bit),
    .busy      (seq_busy),
    .end_prog  (end_prog),
    .end_sense (end_sense),
    .lat_bank  (lat_bank),
    .lat_row   (lat_row),
    .lat_bit   (lat_bit)
  );

  otp_fuse_array #(.NUM_BANKS(NUM_BANKS)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (end_prog),
    .prog_bank (lat_bank),
    .prog_row  (lat_row),
    .prog_bit  (lat_bit),
    .ovr_en    (ovr_do),
    .ovr_bank  (win_bank),
    .ovr_row   (win_row),
    .ovr_data  (wbyte),
    .win_bank  (win_bank),
    .win_row   (win_row),
    .win_byte  (win_byte),
    .sns_bank  (lat_bank),
    .sns_row   (lat_row),
    .sns_byte  (sns_byte)
  );

  always_comb begin
    bus_rdata = '0;
    if (win_hit) begin
      bus_rdata[7:0] = win_rd_prot ? 8'h00 : win_byte;
    end else if (reg_sel) begin
      unique case (ofs)
        OFS_FCTL:  bus_rdata[7:0] = {1'b0, fctl_len_q, 4'b0000};
        OFS_UADDR: bus_rdata[7:0] = {2'b00, ua_q};
        OFS_LADDR: bus_rdata[7:0] = la_q;
        OFS_KEY:   bus_rdata[7:0] = key_q;
        OFS_SDATA: bus_rdata[7:0] = sdat_q;
        OFS_STAT:  bus_rdata[7:0] = {seq_busy, 5'b00000, prgd_q, snsd_q};
        OFS_STATM: bus_rdata[7:0] = {6'b000000, statm_q};
        OFS_ERR:   bus_rdata[7:0] = err_q;
        OFS_ERRM:  bus_rdata[7:0] = errm_q;
        OFS_PREV:  bus_rdata[7:0] = PROD_REV;
        OFS_SREV:  bus_rdata[7:0] = SIL_REV;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_fuse_chk.sv
`timescale 1ns/1ps
module otp_fuse_chk #(
  parameter int BUSY_CYCLES = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       end_prog,
  input logic       sns_ok,
  input logic       sns_fail,
  input logic       acc_prog,
  input logic       acc_sense,
  input logic       rej_key,
  input logic       rej_wp,
  input logic       ovr_blocked,
  input logic       rd_blocked,
  input logic       prgd,
  input logic       snsd,
  input logic [7:0] err_q,
  input logic [7:0] err_set,
  input logic       err_wipe
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_len < BUSY_CYCLES - 1) |=> busy);

  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_len == BUSY_CYCLES - 1) |=> !busy);

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc_prog || acc_sense));

  assert_prog_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_prog |=> prgd);

  assert_key_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_key |=> (err_q[7] && !busy));

  assert_wp_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rej_wp |=> (err_q[6] && !busy));

  assert_ovr_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_blocked |=> err_q[5]);

  assert_rd_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_blocked |=> err_q[4]);

  assert_sense_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sns_ok |=> snsd);

  assert_sense_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sns_fail |=> err_q[2]);

  assert_err_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_wipe && err_set == 8'h00) |=> (err_q == 8'h00));
endmodule

bind otp_fuse_ctrl otp_fuse_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (seq_busy),
  .end_prog    (end_prog),
  .sns_ok      (sns_ok),
  .sns_fail    (sns_fail),
  .acc_prog    (acc_prog),
  .acc_sense   (acc_sense),
  .rej_key     (rej_key),
  .rej_wp      (rej_wp),
  .ovr_blocked (ovr_blocked),
  .rd_blocked  (rd_blocked),
  .prgd        (prgd_q),
  .snsd        (snsd_q),
  .err_q       (err_q),
  .err_set     (err_set),
  .err_wipe    (err_wipe)
);

// File: tb/test_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module test_otp_fuse_ctrl;
  localparam int NB = 8;
  localparam int BC = 6;
  localparam logic [7:0] PREV_V = 8'h31;
  localparam logic [7:0] SREV_V = 8'h02;

  localparam logic [11:0] A_FCTL = 12'd0, A_UA = 12'd1, A_LA = 12'd2, A_KEY = 12'd3,
                          A_SDAT = 12'd4, A_STAT = 12'd5, A_STATM = 12'd6, A_ERR = 12'd7,
                          A_ERRM = 12'd8, A_PREV = 12'd9, A_SREV = 12'd10;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, irq;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NB-1:0] rd_prot = '0, wr_prot = '0, ovr_prot = '0;

  int total = 0, bad = 0;
  logic [7:0] m_sh [NB*256];
  logic [7:0] m_fu [NB*256];

  always #2.5 clk = ~clk;

  otp_fuse_ctrl #(.NUM_BANKS(NB), .BUSY_CYCLES(BC), .PROD_REV(PREV_V), .SIL_REV(SREV_V)) i_otp_fuse_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_prot(rd_prot), .wr_prot(wr_prot),
    .ovr_prot(ovr_prot), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [11:0] win(input int b, input int w);
    return 12'(12'h800 + b * 256 + w);
  endfunction

  function automatic logic [7:0] pat(input int b, input int w);
    return 8'(b * 37 + w * 11 + 5);
  endfunction

  task automatic set_addr(input int b, input int w, input int bt);
    wr(A_UA, 32'((b << 3) | (w >> 5)));
    wr(A_LA, 32'(((w & 31) << 3) | bt));
  endtask

  task automatic wait_idle;
    logic [31:0] s;
    s = 32'h80;
    for (int n = 0; n < 100 && s[7]; n++) rd(A_STAT, s);
  endtask

  task automatic clear_flags;
    wr(A_STAT, 32'hFF);
    wr(A_ERR, 32'hFF);
  endtask

  task automatic prog(input int b, input int w, input int bt);
    set_addr(b, w, bt);
    wr(A_FCTL, 32'h01);
    wait_idle();
  endtask

  task automatic sense(input int b, input int w, output logic [31:0] d);
    set_addr(b, w, 0);
    wr(A_FCTL, 32'h08);
    wait_idle();
    rd(A_SDAT, d);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v, sd_keep;
    int n;
    for (int i = 0; i < NB * 256; i++) begin m_sh[i] = 8'h00; m_fu[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(A_FCTL, v);  chk("R1 fctl", v, 0);
    rd(A_UA, v);    chk("R1 ua", v, 0);
    rd(A_LA, v);    chk("R1 la", v, 0);
    rd(A_KEY, v);   chk("R1 key", v, 0);
    rd(A_SDAT, v);  chk("R1 sdat", v, 0);
    rd(A_STAT, v);  chk("R1 stat", v, 0);
    rd(A_STATM, v); chk("R1 statm", v, 0);
    rd(A_ERR, v);   chk("R1 err", v, 0);
    rd(A_ERRM, v);  chk("R1 errm", v, 0);
    rd(A_PREV, v);  chk("R1 prev", v, 32'(PREV_V));
    rd(A_SREV, v);  chk("R1 srev", v, 32'(SREV_V));
    chk("R1 irq", 32'(irq), 0);
    rd(win(5, 77), v); chk("R2 shadow reset", v, 0);

    // R2: override every shadow byte, read back all
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < 256; w++) begin
        wr(win(b, w), {24'hABCDEF, pat(b, w)});
        m_sh[b * 256 + w] = pat(b, w);
      end
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < 256; w++) begin
        rd(win(b, w), v);
        chk("R2 window", v, 32'(m_sh[b * 256 + w]));
      end

    // R9: busy length, measured on first program
    wr(A_KEY, 32'hAA);
    set_addr(0, 1, 0);
    wr(A_FCTL, 32'h01);
    bus_addr = A_STAT;
    #1 n = 0;
    while (bus_rdata[7] && n < 100) begin n++; @(negedge clk); #1; end
    chk("R9 busy cycles", 32'(n), 32'(BC));
    m_fu[1] |= 8'h01; m_sh[1] |= 8'h01;
    rd(A_STAT, v); chk("R6 prog done", v, 32'h02);
    wr(A_STAT, v);
    rd(A_STAT, v); chk("R10 stat w1c", v, 0);

    // R6/R8: one bit per bank, address split sweep
    for (int b = 1; b < NB; b++) begin
      int w;
      w = b * 33 + 1;
      prog(b, w, b);
      m_fu[b * 256 + w] |= 8'(1 << b);
      m_sh[b * 256 + w] |= 8'(1 << b);
      rd(A_STAT, v); chk("R6 prog done", v, 32'h02);
      clear_flags();
      sense(b, w, v); chk("R8 sense byte", v, 32'(m_fu[b * 256 + w]));
      rd(A_STAT, v); chk("R8 sense done", v, 32'h01);
      clear_flags();
      sense(b, w + 1, v); chk("R6 neighbour untouched", v, 0);
      clear_flags();
    end

    // R6: byte 0xA5 needs one cycle per set bit
    for (int bt = 0; bt < 8; bt++)
      if (bt == 0 || bt == 2 || bt == 5 || bt == 7) prog(0, 200, bt);
    m_fu[200] |= 8'hA5; m_sh[200] |= 8'hA5;
    sense(0, 200, v); chk("R6 multi bit", v, 32'hA5);
    clear_flags();

    // R5: wrong key
    wr(A_KEY, 32'h55);
    set_addr(4, 9, 3);
    wr(A_FCTL, 32'h01);
    rd(A_STAT, v); chk("R5 no cycle", v, 0);
    rd(A_ERR, v);  chk("R5 key error", v, 32'h80);
    wr(A_ERR, v);
    rd(A_ERR, v);  chk("R10 err w1c", v, 0);
    wr(A_KEY, 32'hAA);
    sense(4, 9, v); chk("R5 fuse unchanged", v, 0);
    clear_flags();

    // R7: write protect
    wr_prot[2] = 1'b1;
    prog(2, 7, 1);
    rd(A_STAT, v); chk("R7 no prog done", v, 0);
    rd(A_ERR, v);  chk("R7 wp error", v, 32'h40);
    wr_prot[2] = 1'b0;
    clear_flags();
    sense(2, 7, v); chk("R7 fuse unchanged", v, 0);
    clear_flags();

    // R3: override protect
    ovr_prot[1] = 1'b1;
    wr(win(1, 5), 32'h3C);
    rd(A_ERR, v); chk("R3 ovr error", v, 32'h20);
    rd(win(1, 5), v); chk("R3 shadow kept", v, 32'(m_sh[256 + 5]));
    ovr_prot[1] = 1'b0;
    clear_flags();

    // R4 + R11: read protect and irq masking
    wr(A_ERRM, 32'h10);
    rd_prot[3] = 1'b1;
    chk("R11 irq low before", 32'(irq), 0);
    rd(win(3, 0), v); chk("R4 read blocked", v, 0);
    rd(A_ERR, v); chk("R4 rd error", v, 32'h10);
    chk("R11 irq on masked error", 32'(irq), 1);

    // R8: sense of read-protected bank fails, sdat kept
    rd(A_SDAT, sd_keep);
    sense(3, 100, v); chk("R8 sdat kept", v, sd_keep);
    rd(A_STAT, v); chk("R8 no sense done", v, 0);
    rd(A_ERR, v);  chk("R8 sense error", v, 32'h14);
    rd_prot[3] = 1'b0;
    wr(A_ERR, v);
    chk("R11 irq cleared", 32'(irq), 0);
    wr(A_STATM, 32'h01);
    sense(0, 200, v);
    chk("R11 irq on sense done", 32'(irq), 1);
    wr(A_STAT, 32'h02);
    chk("R11 irq other bit", 32'(irq), 1);
    clear_flags();
    chk("R11 irq after clear", 32'(irq), 0);
    wr(A_STATM, 0); wr(A_ERRM, 0);

    // R9: requests during busy ignored
    set_addr(0, 200, 0);
    wr(A_FCTL, 32'h08);
    set_addr(5, 3, 0);
    wr(A_FCTL, 32'h71);
    wait_idle();
    rd(A_STAT, v); chk("R9 only sense done", v, 32'h01);
    rd(A_ERR, v);  chk("R9 no error", v, 0);
    rd(A_SDAT, v); chk("R9 latched address", v, 32'hA5);
    rd(A_FCTL, v); chk("R9 fctl write ignored", v, 0);
    clear_flags();
    sense(5, 3, v); chk("R9 no program", v, 0);
    clear_flags();

    // R12: both start bits, pulse field
    set_addr(6, 2, 4);
    wr(A_FCTL, 32'h09);
    wait_idle();
    m_fu[6 * 256 + 2] |= 8'h10; m_sh[6 * 256 + 2] |= 8'h10;
    rd(A_STAT, v); chk("R12 program only", v, 32'h02);
    clear_flags();
    sense(6, 2, v); chk("R12 programmed", v, 32'h10);
    clear_flags();
    wr(A_FCTL, 32'h50);
    rd(A_FCTL, v); chk("R12 pulse field", v, 32'h50);
    rd(A_STAT, v); chk("R12 no start", v, 0);

    // R2/R6: final shadow sweep against model
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < 256; w++) begin
        rd(win(b, w), v);
        chk("R2 final shadow", v, 32'(m_sh[b * 256 + w]));
      end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule